// File: doc/BRIEF.md
# Byte-Lane Static Memory Model

This block is a synthesizable, clock-sampled model of a 16-bit-wide static memory driven by active-low strobes: a chip select, a write strobe, an output strobe and one enable per byte lane. The bidirectional data bus is split into a data-in vector, a data-out vector and one drive-enable bit per byte lane. A pad ring or a board-level bench joins them into a tri-state bus.

Each clock the model decodes the strobes into one of four modes: deselected, read, output-off or write. In a read, only the lanes whose enable is low are driven. A write lasts as long as chip select and write strobe are both low. The stored word is updated on the first clock after that overlap ends, whichever strobe ends it. The full address is 17 bits. A parameter sets how many low address bits index the storage, so a short simulation can use a small array.

This is a pin-level memory port, not a stream, so it has no valid/ready handshake and no back-pressure. Every pin is a plain level that is sampled or driven each cycle.

Top module: `sram_byte_lane`

## Requirements
- R1: Storage holds 2**DEPTH_W words of 16 bits, indexed by the low DEPTH_W bits of the 17-bit address. Higher address bits are ignored, so addresses that differ only above bit DEPTH_W-1 alias. The default DEPTH_W is 10.
- R2: While cs_n is high, dq_oe is 2'b00 and dout is zero, whatever the other strobes are.
- R3: With cs_n low, we_n high and oe_n low (read), lane i drives (dq_oe[i]=1) exactly when be_n[i] is low, and that lane of dout carries the stored byte. Lane 0 is dout[7:0] under be_n[0]; lane 1 is dout[15:8] under be_n[1].
- R4: With cs_n low, we_n high and oe_n high, no lane drives.
- R5: With cs_n and we_n both low (write), no lane drives, whatever the level of oe_n.
- R6: A write commits at the first clock edge where the overlap of low cs_n and low we_n is sampled false after having been sampled true. Address, data and lane enables are taken from the last clock of the overlap. The new data is readable from the cycle after the terminating cycle.
- R7: A write updates only the lanes whose be_n bit was low on the last overlap clock. Other lanes keep their old contents.
- R8: When both be_n bits are high, no lane drives even in read mode, and a write changes no stored data.
- R9: A rising cs_n ends a write exactly as a rising we_n does.
- R10: A lane that is not driving presents zero on its dout bits.
- R11: Asserting rst_n low drops any write still in progress, so that word keeps its previous contents. Stored data is not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of write tracking |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| be_n | input | 2 | Byte lane enables, active low; bit 0 low byte |
| addr | input | 17 | Word address |
| din | input | 16 | Write data from the bus |
| dout | output | 16 | Read data to the bus |
| dq_oe | output | 2 | Per-lane bus drive enable |

## Verification
A corrupted pending-write register shows up only after the write ends. The wrong address, data or lane mask appears on the first read of the affected word, one cycle after the terminating strobe. A broken mode decode is visible in the same cycle as the strobe change, as a lane that drives when it should float or floats when it should drive. The scoreboard therefore checks drive enables on every mode cycle, and checks data only on reads placed after commits. A lost or doubled lane mask shows as a changed neighbour byte on the next read of that word.

// File: rtl/sram_bl_pkg.sv
package sram_bl_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_READ  = 2'd1,
    MODE_QUIET = 2'd2,
    MODE_WRITE = 2'd3
  } mode_e;

  // Write wins over output strobe; deselect wins over everything.
  function automatic mode_e decode_mode(input logic cs_n, input logic we_n,
                                        input logic oe_n);
    if (cs_n)       return MODE_OFF;
    else if (!we_n) return MODE_WRITE;
    else if (!oe_n) return MODE_READ;
    else            return MODE_QUIET;
  endfunction

endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
  import sram_bl_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             cs_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] be_n,
  output mode_e            mode,
  output logic [LANES-1:0] lane_drive
);

  assign mode = decode_mode(cs_n, we_n, oe_n);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_drive[g] = (mode == MODE_READ) && !be_n[g];
  end

endmodule

// File: rtl/sram_write_ctrl.sv
module sram_write_ctrl #(
  parameter int IDX_W  = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic [LANES-1:0]  be_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] din,
  output logic              commit,
  output logic [IDX_W-1:0]  cmt_idx,
  output logic [DATA_W-1:0] cmt_data,
  output logic [LANES-1:0]  cmt_lane
);

  logic overlap;
  logic pend_q;

  assign overlap = !cs_n && !we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      cmt_idx  <= '0;
      cmt_data <= '0;
      cmt_lane <= '0;
    end else begin
      pend_q <= overlap;
      if (overlap) begin
        cmt_idx  <= idx;
        cmt_data <= din;
        cmt_lane <= ~be_n;
      end
    end
  end

  assign commit = pend_q && !overlap && rst_n;

  // R6: a commit only follows a sampled strobe overlap that has now ended
  a_r6_commit_after_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($past(!cs_n && !we_n) && !(!cs_n && !we_n)));

  // R9: chip select rising out of an overlap produces a commit
  a_r9_cs_terminates: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cs_n && !we_n) && $rose(cs_n) && $past(rst_n)) |-> commit);

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int IDX_W  = 10,
  parameter int LANE_W = 8,
  localparam int WORDS = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LANE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LANE_W-1:0] rd_data
);

  logic [LANE_W-1:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_idx] <= wr_data;
  end

  assign rd_data = cells[rd_idx];

endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane
  import sram_bl_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DEPTH_W = 10,
  parameter int LANES   = 2,
  parameter int LANE_W  = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [LANES-1:0]  be_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [LANES-1:0]  dq_oe
);

  mode_e             mode;
  logic [LANES-1:0]  lane_drive;
  logic [DEPTH_W-1:0] idx;
  logic              commit;
  logic [DEPTH_W-1:0] cmt_idx;
  logic [DATA_W-1:0] cmt_data;
  logic [LANES-1:0]  cmt_lane;

  assign idx = addr[DEPTH_W-1:0];

  if (DEPTH_W < ADDR_W) begin : g_alias
    logic unused_hi;
    assign unused_hi = ^addr[ADDR_W-1:DEPTH_W];
  end

  sram_mode_decode #(.LANES(LANES)) u_decode (
    .cs_n       (cs_n),
    .we_n       (we_n),
    .oe_n       (oe_n),
    .be_n       (be_n),
    .mode       (mode),
    .lane_drive (lane_drive)
  );

  sram_write_ctrl #(.IDX_W(DEPTH_W), .LANES(LANES), .LANE_W(LANE_W)) u_wctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .we_n     (we_n),
    .be_n     (be_n),
    .idx      (idx),
    .din      (din),
    .commit   (commit),
    .cmt_idx  (cmt_idx),
    .cmt_data (cmt_data),
    .cmt_lane (cmt_lane)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] rd_byte;

    sram_lane_array #(.IDX_W(DEPTH_W), .LANE_W(LANE_W)) u_array (
      .clk     (clk),
      .wr_en   (commit && cmt_lane[g]),
      .wr_idx  (cmt_idx),
      .wr_data (cmt_data[g*LANE_W +: LANE_W]),
      .rd_idx  (idx),
      .rd_data (rd_byte)
    );

    assign dout[g*LANE_W +: LANE_W] = lane_drive[g] ? rd_byte : '0;
  end

  assign dq_oe = lane_drive;

  // R2: deselect floats the bus and zeroes the read data
  a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (dq_oe == '0 && dout == '0));

  // R5: no lane drives while both write strobes overlap
  a_r5_write_floats: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |-> (dq_oe == '0));

  // R3: in a read the drive pattern mirrors the lane enables
  a_r3_lane_follows_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && we_n && !oe_n) |-> (dq_oe == ~be_n));

  // R8: no enabled lane means no drive in any mode
  a_r8_no_lane_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (&be_n) |-> (dq_oe == '0));

  // R4: output strobe high with write strobe high floats the bus
  a_r4_output_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && we_n && oe_n) |-> (dq_oe == '0));

endmodule

// File: tb/sram_byte_lane_bench.sv
module sram_byte_lane_bench;

  localparam int CLK_P = 10;
  localparam int DW    = 10;

  typedef struct {
    logic [15:0] dout;
    logic [1:0]  oe;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [1:0]  be_n = 2'b11;
  logic [16:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [1:0]  dq_oe;

  exp_t        sb_q[$];
  logic [15:0] model [1 << DW];
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sram_byte_lane u_sram_byte_lane (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .be_n(be_n), .addr(addr), .din(din), .dout(dout), .dq_oe(dq_oe)
  );

  // Monitor: samples a quarter period after the driving edge
  always @(negedge clk) begin
    #(CLK_P/4);
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (dout !== e.dout || dq_oe !== e.oe) begin
        fails++;
        $display("FAIL %s: dout=%h oe=%b expected dout=%h oe=%b",
                 e.tag, dout, dq_oe, e.dout, e.oe);
      end
    end
  end

  task automatic cyc(input logic c, input logic w, input logic o,
                     input logic [1:0] b, input logic [16:0] a,
                     input logic [15:0] d, input bit chk, input string tag);
    exp_t e;
    @(negedge clk);
    cs_n = c; we_n = w; oe_n = o; be_n = b; addr = a; din = d;
    if (chk) begin
      e.tag = tag; e.dout = '0; e.oe = 2'b00;
      if (!c && w && !o) begin
        for (int i = 0; i < 2; i++) begin
          if (!b[i]) begin
            e.oe[i] = 1'b1;
            e.dout[i*8 +: 8] = model[a[DW-1:0]][i*8 +: 8];
          end
        end
      end
      sb_q.push_back(e);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [15:0] d,
                    input logic [1:0] b, input bit by_cs, input string tag);
    cyc(1'b0, 1'b0, 1'b0, b, a, d, 1'b1, {tag, "/R5"});
    if (by_cs) cyc(1'b1, 1'b0, 1'b1, b, a, d, 1'b1, {tag, "/R9/R2"});
    else       cyc(1'b0, 1'b1, 1'b1, b, a, d, 1'b1, {tag, "/R4"});
    for (int i = 0; i < 2; i++)
      if (!b[i]) model[a[DW-1:0]][i*8 +: 8] = d[i*8 +: 8];
  endtask

  task automatic rd(input logic [16:0] a, input logic [1:0] b, input string tag);
    cyc(1'b0, 1'b1, 1'b0, b, a, 16'h0, 1'b1, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cyc(1'b1, 1'b1, 1'b1, 2'b11, '0, '0, 1'b1, "R11 reset state");
    @(negedge clk); rst_n = 1'b1;
    cyc(1'b1, 1'b0, 1'b0, 2'b00, 17'h3, 16'hFFFF, 1'b1, "R2 deselect");

    // Full-word writes, we-terminated and cs-terminated (R6, R9)
    wr(17'h00010, 16'hA55A, 2'b00, 1'b0, "R6 full");
    wr(17'h00020, 16'h1234, 2'b00, 1'b1, "R9 full");
    rd(17'h00010, 2'b00, "R6 read full");
    rd(17'h00020, 2'b00, "R9 read cs-ended");

    // Single-lane writes keep the other byte (R7)
    wr(17'h00010, 16'hEE77, 2'b10, 1'b0, "R7 low lane");
    rd(17'h00010, 2'b00, "R7 high byte kept");
    wr(17'h00020, 16'h9900, 2'b01, 1'b1, "R7 high lane");
    rd(17'h00020, 2'b00, "R7 low byte kept");

    // Per-lane reads and the zeroed idle lane (R3, R10)
    rd(17'h00010, 2'b10, "R3 low lane only R10");
    rd(17'h00010, 2'b01, "R3 high lane only R10");
    rd(17'h00010, 2'b11, "R8 no lane read");
    cyc(1'b0, 1'b1, 1'b1, 2'b00, 17'h10, '0, 1'b1, "R4 output off");
    cyc(1'b0, 1'b0, 1'b1, 2'b00, 17'h30, 16'h0BAD, 1'b1, "R5 write oe high");
    cyc(1'b0, 1'b1, 1'b1, 2'b11, 17'h30, '0, 1'b0, "");
    model[17'h30] = 16'h0BAD;
    rd(17'h00030, 2'b00, "R5 write with oe high stored");

    // Write with no lane enabled changes nothing (R8)
    wr(17'h00010, 16'h0000, 2'b11, 1'b0, "R8 masked write");
    rd(17'h00010, 2'b00, "R8 word unchanged");

    // Multi-cycle write: last overlap cycle wins (R6)
    cyc(1'b0, 1'b0, 1'b1, 2'b00, 17'h40, 16'h1111, 1'b1, "R6 long write a");
    cyc(1'b0, 1'b0, 1'b1, 2'b10, 17'h40, 16'h2222, 1'b1, "R6 long write b");
    cyc(1'b0, 1'b0, 1'b1, 2'b00, 17'h40, 16'hC3D4, 1'b1, "R6 long write c");
    cyc(1'b0, 1'b1, 1'b1, 2'b00, 17'h40, 16'h0, 1'b1, "R6 long write end");
    model[17'h40] = 16'hC3D4;
    rd(17'h00040, 2'b00, "R6 last data captured");

    // Aliasing above the index width (R1)
    wr(17'h00005, 16'h5A5A, 2'b00, 1'b0, "R1 base");
    rd(17'h10405, 2'b00, "R1 alias read");
    wr(17'h08C07, 16'h7E81, 2'b00, 1'b1, "R1 alias write");
    rd(17'h00007, 2'b00, "R1 alias readback");

    // Reset drops an unfinished write (R11)
    cyc(1'b0, 1'b0, 1'b1, 2'b00, 17'h10, 16'hDEAD, 1'b0, "");
    @(negedge clk); rst_n = 1'b0; we_n = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    rd(17'h00010, 2'b00, "R11 reset dropped write");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule